// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat in a short burst to a synchronous memory. A load cycle captures a full external address. Each advance cycle after it moves the low address bits to the next beat, and the upper bits keep the loaded value. The low bits follow one of two orders. Linear order adds the beat count to the start offset and wraps. Interleaved order XORs the start offset with the beat count. A static order input selects between them.

A clock-enable style stall input freezes the whole block. The address output is registered, so a load or an advance becomes visible one clock after the edge that samples it. A burst flag reports that at least one advance has happened since the most recent load.

Top module: `burst_addr_ctr`

## Requirements
- R1: During and just after the asynchronous active-low reset, addr_o is all zeros and burst_o is 0.
- R2: On an edge where stall_i is 0 and adv_i is 0, the block loads. After that edge addr_o equals addr_i and burst_o is 0.
- R3: On an edge where stall_i is 0 and adv_i is 1, addr_i is ignored. Bits above the burst field of addr_o (bits ADDR_W-1 down to BURST_W) keep their loaded value.
- R4: When order_i was 1 at the load, the burst field addr_o[BURST_W-1:0] after the n-th advance equals start_low XOR (n mod 2**BURST_W).
- R5: When order_i was 0 at the load, the burst field after the n-th advance equals (start_low + n) mod 2**BURST_W.
- R6: After 2**BURST_W advances the burst field returns to the loaded start value, and stepping continues in the same order.
- R7: On an edge where stall_i is 1, addr_o and burst_o keep their values. This holds even if adv_i is 0 or addr_i changes.
- R8: order_i is sampled only on load edges. A change during a burst does not alter the order of that burst.
- R9: burst_o goes to 1 after the first advance that follows a load. It stays 1 until the next load, including across a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 = hold all state this cycle |
| adv_i | input | 1 | 1 = advance to next beat, 0 = load addr_i |
| order_i | input | 1 | 1 = interleaved order, 0 = linear order (sampled on load) |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |
| burst_o | output | 1 | 1 = at least one advance since the last load |

## Verification
The bench builds the block with ADDR_W=16 and the default BURST_W=2. The upper field is then wide enough to show that random addr_i values driven during advances never leak in. The four-beat sequence is short, so every start offset in both orders can run through a full wrap. Stall cycles are placed between loads and advances, and order_i is toggled in the middle of bursts. This exposes any state that moves while stalled and any order that is taken from the live pin instead of from the load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_ord_e        mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mode_o <= ORD_INTERLEAVE;
    end else if (load_i) begin
      base_o <= addr_i;
      mode_o <= burst_ord_e'(order_i);
    end
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_o));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] beat_o,
  output logic               burst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o  <= '0;
      burst_o <= 1'b0;
    end else if (load_i) begin
      beat_o  <= '0;
      burst_o <= 1'b0;
    end else if (step_i) begin
      beat_o  <= beat_o + 1'b1;
      burst_o <= 1'b1;
    end
  end

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> beat_o == BURST_W'($past(beat_o) + 1'b1));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(beat_o) && $stable(burst_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  input  burst_ord_e         mode_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] ilv_low;

  genvar g;
  generate
    for (g = 0; g < BURST_W; g++) begin : g_ilv
      assign ilv_low[g] = start_i[g] ^ beat_i[g];
    end
  endgenerate

  assign lin_low = start_i + beat_i;
  assign low_o   = (mode_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               load;
  logic               step;
  logic [ADDR_W-1:0]  base;
  burst_ord_e         mode;
  logic [BURST_W-1:0] beat;
  logic [BURST_W-1:0] low;

  assign load = !stall_i && !adv_i;
  assign step = !stall_i && adv_i;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .order_i(order_i),
    .base_o (base),
    .mode_o (mode)
  );

  burst_beat_ctr #(.BURST_W(BURST_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .beat_o (beat),
    .burst_o(burst_o)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .start_i(base[BURST_W-1:0]),
    .beat_i (beat),
    .mode_i (mode),
    .low_o  (low)
  );

  assign addr_o = {base[ADDR_W-1:BURST_W], low};

  assert_upper_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> addr_o[ADDR_W-1 -: HI_W] == $past(addr_o[ADDR_W-1 -: HI_W]));
  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(addr_o) && $stable(burst_o));
  assert_load_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> addr_o == $past(addr_i) && !burst_o);
  assert_burst_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_o) |-> $past(load));
endmodule

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;
  localparam int AW = 16;
  localparam int BW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stall_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          order_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          burst_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          burst;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_n = '0;
  logic          m_mode = 1'b1;
  logic          m_burst = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_ctr #(.ADDR_W(AW), .BURST_W(BW)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stall_i(stall_i),
    .adv_i  (adv_i),
    .order_i(order_i),
    .addr_i (addr_i),
    .addr_o (addr_o),
    .burst_o(burst_o)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [BW-1:0] lo;
    lo = m_mode ? (m_base[BW-1:0] ^ m_n) : BW'(m_base[BW-1:0] + m_n);
    return {m_base[AW-1:BW], lo};
  endfunction

  task automatic cycle(input logic st, input logic adv, input logic ord,
                       input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk_i);
    stall_i = st; adv_i = adv; order_i = ord; addr_i = a;
    if (!st) begin
      if (!adv) begin
        m_base = a; m_n = '0; m_mode = ord; m_burst = 1'b0;
      end else begin
        m_n = m_n + 1'b1; m_burst = 1'b1;
      end
    end
    e.addr = model_addr(); e.burst = m_burst; e.tag = tag;
    sb_q.push_back(e);
  endtask

  always begin
    @(posedge clk_i);
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (addr_o !== e.addr || burst_o !== e.burst) begin
        errors++;
        $display("FAIL %s: addr=%h burst=%b expected addr=%h burst=%b",
                 e.tag, addr_o, burst_o, e.addr, e.burst);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23;
    checks++;
    if (addr_o !== '0 || burst_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: addr=%h burst=%b expected addr=0 burst=0", addr_o, burst_o);
    end
    rst_ni = 1'b1;

    // R4 interleaved, every start offset, full wrap (R6) and burst flag (R9)
    for (int s = 0; s < 4; s++) begin
      cycle(1'b0, 1'b0, 1'b1, AW'(16'hA5C0 | s), "R2");
      for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1, 1'b1, AW'(16'h3333 + k), "R4_R6_R9");
    end
    // R5 linear, every start offset
    for (int s = 0; s < 4; s++) begin
      cycle(1'b0, 1'b0, 1'b0, AW'(16'h1234 & 16'hFFFC | s), "R2");
      for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1, 1'b0, AW'(16'hFFFF - k), "R5_R6_R3");
    end
    // R7 stalls mid-burst, including a would-be load
    cycle(1'b0, 1'b0, 1'b0, 16'h7E01, "R2");
    cycle(1'b0, 1'b1, 1'b0, 16'h0000, "R5");
    cycle(1'b1, 1'b0, 1'b1, 16'hBEEF, "R7");
    cycle(1'b1, 1'b1, 1'b0, 16'hCAFE, "R7");
    cycle(1'b0, 1'b1, 1'b0, 16'h0000, "R5");
    // R7 stall right after load keeps burst_o low
    cycle(1'b0, 1'b0, 1'b1, 16'h4442, "R2");
    cycle(1'b1, 1'b1, 1'b0, 16'h9999, "R7_R9");
    cycle(1'b0, 1'b1, 1'b1, 16'h9999, "R4_R9");
    // R8 order toggled mid-burst
    cycle(1'b0, 1'b0, 1'b0, 16'h0803, "R2");
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1, k[0], 16'h5555, "R8");
    cycle(1'b0, 1'b0, 1'b1, 16'h0801, "R2");
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1, ~k[0], 16'hAAAA, "R8");
    // back-to-back loads
    cycle(1'b0, 1'b0, 1'b0, 16'h1111, "R2");
    cycle(1'b0, 1'b0, 1'b1, 16'h2222, "R2");
    cycle(1'b0, 1'b1, 1'b1, 16'h2222, "R4");
    @(negedge clk_i);
    stall_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule